// File: doc/BRIEF.md
# GPIO Pad Controller with Interrupts

This block manages 128 general-purpose lines through a plain 32-bit register port. Each line owns one configuration word. The word sets the value the line drives, whether the output driver and the input receiver are switched off, and which input condition raises an event. The same word also returns the line's synchronised input level. Lock bits are loaded from a strap input during reset. A line whose lock bit is set keeps its configuration word no matter what is written to it.

Each input passes through two synchroniser flops. An edge detector and a level detector sit behind them. A detected event sets a sticky status bit. Status bits are grouped 32 to a word, and each status word has a matching enable word. The single interrupt output is high while any status bit and its enable bit are both set. Software clears status by writing a word with zeros in the positions to clear and ones everywhere else.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: While `rst` is high, every configuration word, status bit and enable bit becomes 0, and the lock bits are loaded from `lock_strap`. After reset, `irq` and `pad_out` read 0 and `pad_oe` reads all ones.
- R2: Word address n (0..127) is the configuration word of line n. Its bit layout is: bit 0 = drive value (seen on `pad_out[n]`); bit 1 = synchronised input level (read-only); bit 3 = output off (`pad_oe[n]` = not bit 3); bit 4 = receiver off; bits 25:22 = trigger code. All other bits read 0.
- R3: A write to the configuration word of a locked line has no effect: the word, `pad_out` and `pad_oe` keep their values.
- R4: Read data appears on `bus_rdata` one clock after the read request. Word addresses 128+w, 132+w and 136+w (w = 0..3) hold status, enable and lock word w, where line n maps to word n/32, bit n%32. Lock words cannot be written. Unmapped addresses read 0.
- R5: Trigger code 1 selects rising-edge events: a 0 then 1 sequence on the synchronised input sets the status bit on the third clock after the pin rises, and only once per rise.
- R6: Trigger code 0 selects high-level events: the status bit is set on every clock while the synchronised input is high.
- R7: Trigger codes 2 to 15 generate no events, and a set receiver-off bit blocks events in every mode.
- R8: A write to a status word clears exactly the bits written as 0. An event that occurs in the same cycle as a clear keeps the bit set.
- R9: `irq` is high exactly when some status bit and its enable bit are both 1. Status bits are set whether or not the line is enabled.
- R10: The input level bit of a configuration word follows the pin after two clocks of synchronisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_strap | input | 128 | Per-line lock values captured during reset |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, one cycle after the request |
| pad_in | input | 128 | Asynchronous line inputs |
| pad_out | output | 128 | Drive value per line |
| pad_oe | output | 128 | Output enable per line |
| irq | output | 1 | Combined interrupt |

## Verification
Read data is due at the first falling edge after the clock edge that accepts the read. The scoreboard expects a result only in that slot, so a result one cycle early or late fails. A pin change made at a falling edge reaches the input level bit after two rising edges and the status bit after three. The bench samples `irq` at the falling edge after the second rising edge, where it must still be low, and again after the third, where it must be high. Writes take effect at the edge that accepts them. Because `irq` is combinational from status and enable, it is checked at the falling edge straight after a write.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

    localparam int WORD_W   = 32;
    localparam int TRIG_LSB = 22;
    localparam int TRIG_W   = 4;

    localparam logic [TRIG_W-1:0] TRIG_LEVEL = 4'd0;
    localparam logic [TRIG_W-1:0] TRIG_RISE  = 4'd1;

    typedef struct packed {
        logic [TRIG_W-1:0] trig;
        logic              rx_off;
        logic              tx_off;
        logic              drive;
    } pad_cfg_t;

    typedef enum logic [2:0] {
        RG_PAD,
        RG_STATUS,
        RG_ENABLE,
        RG_LOCK,
        RG_NONE
    } region_e;

    function automatic pad_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        pad_cfg_t c;
        c.drive  = w[0];
        c.tx_off = w[3];
        c.rx_off = w[4];
        c.trig   = w[TRIG_LSB +: TRIG_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] word_from_cfg(input pad_cfg_t c, input logic lvl);
        logic [WORD_W-1:0] w;
        w = '0;
        w[0] = c.drive;
        w[1] = lvl;
        w[3] = c.tx_off;
        w[4] = c.rx_off;
        w[TRIG_LSB +: TRIG_W] = c.trig;
        return w;
    endfunction

endpackage

// File: rtl/gpio_pad_line.sv
module gpio_pad_line
    import gpio_pad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pin,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output pad_cfg_t          cfg,
    output logic              level,
    output logic              hit
);

    logic meta_q, sync_q, prev_q;
    pad_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
            cfg_q  <= '0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            prev_q <= sync_q;
            if (wr_en) cfg_q <= cfg_from_word(wdata);
        end
    end

    always_comb begin
        hit = 1'b0;
        if (!cfg_q.rx_off) begin
            if (cfg_q.trig == TRIG_RISE)  hit = sync_q && !prev_q;
            if (cfg_q.trig == TRIG_LEVEL) hit = sync_q;
        end
    end

    assign cfg   = cfg_q;
    assign level = sync_q;

endmodule

// File: rtl/gpio_irq_word.sv
module gpio_irq_word
    import gpio_pad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] hit,
    input  logic              st_wr,
    input  logic              en_wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] status,
    output logic [WORD_W-1:0] enable,
    output logic              any
);

    logic [WORD_W-1:0] status_q, enable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= (st_wr ? (status_q & wdata) : status_q) | hit;
            if (en_wr) enable_q <= wdata;
        end
    end

    assign status = status_q;
    assign enable = enable_q;
    assign any    = |(status_q & enable_q);

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pad_pkg::*;
#(
    parameter int NUM_LINES = 128,
    parameter int ADDR_W    = 8
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lock_strap,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic                 irq
);

    localparam int NUM_WORDS  = NUM_LINES / WORD_W;
    localparam int LINE_IDX_W = $clog2(NUM_LINES);
    localparam int WORD_IDX_W = $clog2(NUM_WORDS);
    localparam logic [ADDR_W-1:0] PAD_END  = ADDR_W'(NUM_LINES);
    localparam logic [ADDR_W-1:0] ST_END   = ADDR_W'(NUM_WORDS);
    localparam logic [ADDR_W-1:0] EN_END   = ADDR_W'(2 * NUM_WORDS);
    localparam logic [ADDR_W-1:0] LOCK_END = ADDR_W'(3 * NUM_WORDS);

    region_e                 region;
    logic [ADDR_W-1:0]       off;
    logic [LINE_IDX_W-1:0]   line_idx;
    logic [WORD_IDX_W-1:0]   word_idx;
    logic                    wr;

    pad_cfg_t                cfg_arr [NUM_LINES];
    logic [NUM_LINES-1:0]    level_all, hit_all, lock_q;
    logic [NUM_LINES-1:0]    status_all, enable_all;
    logic [NUM_WORDS-1:0]    word_any;
    logic [WORD_W-1:0]       rdata_q, rdata_d;

    always_comb begin
        off      = bus_addr - PAD_END;
        line_idx = bus_addr[LINE_IDX_W-1:0];
        word_idx = off[WORD_IDX_W-1:0];
        if (bus_addr < PAD_END)  region = RG_PAD;
        else if (off < ST_END)   region = RG_STATUS;
        else if (off < EN_END)   region = RG_ENABLE;
        else if (off < LOCK_END) region = RG_LOCK;
        else                     region = RG_NONE;
    end

    assign wr = bus_valid && bus_write;

    always_ff @(posedge clk) begin
        if (rst) lock_q <= lock_strap;
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic line_wr;
        assign line_wr = wr && (region == RG_PAD) &&
                         (line_idx == LINE_IDX_W'(i)) && !lock_q[i];
        gpio_pad_line u_line (
            .clk   (clk),
            .rst   (rst),
            .pin   (pad_in[i]),
            .wr_en (line_wr),
            .wdata (bus_wdata),
            .cfg   (cfg_arr[i]),
            .level (level_all[i]),
            .hit   (hit_all[i])
        );
        assign pad_out[i] = cfg_arr[i].drive;
        assign pad_oe[i]  = !cfg_arr[i].tx_off;
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic sel;
        assign sel = (word_idx == WORD_IDX_W'(w));
        gpio_irq_word u_word (
            .clk    (clk),
            .rst    (rst),
            .hit    (hit_all[w*WORD_W +: WORD_W]),
            .st_wr  (wr && sel && (region == RG_STATUS)),
            .en_wr  (wr && sel && (region == RG_ENABLE)),
            .wdata  (bus_wdata),
            .status (status_all[w*WORD_W +: WORD_W]),
            .enable (enable_all[w*WORD_W +: WORD_W]),
            .any    (word_any[w])
        );
    end

    always_comb begin
        unique case (region)
            RG_PAD:    rdata_d = word_from_cfg(cfg_arr[line_idx], level_all[line_idx]);
            RG_STATUS: rdata_d = status_all[word_idx*WORD_W +: WORD_W];
            RG_ENABLE: rdata_d = enable_all[word_idx*WORD_W +: WORD_W];
            RG_LOCK:   rdata_d = lock_q[word_idx*WORD_W +: WORD_W];
            default:   rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                         rdata_q <= '0;
        else if (bus_valid && !bus_write) rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;
    assign irq       = |word_any;

endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk #(
    parameter int NUM_LINES = 128,
    parameter int ADDR_W    = 8
)(
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_LINES-1:0] pad_out,
    input logic [NUM_LINES-1:0] pad_oe,
    input logic                 irq,
    input logic [NUM_LINES-1:0] lock_q,
    input logic [NUM_LINES-1:0] enable_all
);

    localparam int NUM_WORDS = NUM_LINES / 32;
    localparam int LW = $clog2(NUM_LINES);
    localparam int WW = $clog2(NUM_WORDS);
    localparam logic [ADDR_W-1:0] PAD_END  = ADDR_W'(NUM_LINES);
    localparam logic [ADDR_W-1:0] LOCK_LO  = ADDR_W'(NUM_LINES + 2 * NUM_WORDS);
    localparam logic [ADDR_W-1:0] LOCK_HI  = ADDR_W'(NUM_LINES + 3 * NUM_WORDS);

    logic pad_wr, lock_rd;
    logic [LW-1:0] lidx;
    logic [WW-1:0] widx;

    assign pad_wr  = bus_valid && bus_write && (bus_addr < PAD_END);
    assign lock_rd = bus_valid && !bus_write && (bus_addr >= LOCK_LO) && (bus_addr < LOCK_HI);
    assign lidx    = bus_addr[LW-1:0];
    assign widx    = bus_addr[WW-1:0];

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && pad_out == '0 && pad_oe == '1));

    assert_pad_write_R2: assert property (@(posedge clk) disable iff (rst)
        (pad_wr && !lock_q[lidx]) |=>
            (pad_out[$past(lidx)] == $past(bus_wdata[0])) &&
            (pad_oe[$past(lidx)] == !$past(bus_wdata[3])));

    assert_locked_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (pad_wr && lock_q[lidx]) |=> ($stable(pad_out) && $stable(pad_oe)));

    assert_lock_read_R4: assert property (@(posedge clk) disable iff (rst)
        lock_rd |=> (bus_rdata == lock_q[$past(widx)*32 +: 32]));

    assert_irq_enabled_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (enable_all != '0));

endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .irq        (irq),
    .lock_q     (lock_q),
    .enable_all (enable_all)
);

// File: tb/test_gpio_pad_ctrl.sv
module test_gpio_pad_ctrl;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] lock_strap = 128'd1 << 100;
    logic         bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] pad_in = '0;
    logic [127:0] pad_out, pad_oe;
    logic         irq;

    int n_cmp = 0, n_bad = 0;
    logic rd_fire = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    gpio_pad_ctrl i_gpio_pad_ctrl (
        .clk(clk), .rst(rst), .lock_strap(lock_strap),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    always @(posedge clk) rd_fire <= bus_valid && !bus_write;

    always @(negedge clk) begin
        if (rd_fire) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (bus_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic check(input logic [127:0] act, input logic [127:0] exp, input string t);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", t, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(irq, 0, "R1 irq");
        check(pad_out, '0, "R1 pad_out");
        check(pad_oe, '1, "R1 pad_oe");
        rd(8'd0, 32'h0, "R1 pad0");
        rd(8'd128, 32'h0, "R1 status0");
        rd(8'd133, 32'h0, "R1 enable1");
        // R4 lock words read-only, unmapped reads 0
        rd(8'd139, 32'h10, "R4 lock3");
        rd(8'd136, 32'h0, "R4 lock0");
        wr(8'd139, 32'h0);
        rd(8'd139, 32'h10, "R4 lock3 after write");
        rd(8'd200, 32'h0, "R4 unmapped");
        // R2 layout, reserved bits
        wr(8'd3, 32'hFFFF_FFFF);
        rd(8'd3, 32'h03C0_0019, "R2 pad3 readback");
        check(pad_out[3], 1, "R2 drive");
        check(pad_oe[3], 0, "R2 oe");
        // R10 input level after sync
        pad_in[3] = 1'b1;
        idle(2);
        rd(8'd3, 32'h03C0_001B, "R10 level bit");
        // R3 locked line
        wr(8'd100, 32'h0000_0019);
        rd(8'd100, 32'h0, "R3 locked word");
        check(pad_out[100], 0, "R3 pad_out");
        check(pad_oe[100], 1, "R3 pad_oe");
        // R5 edge mode on line 5
        wr(8'd5, 32'h0040_0000);
        wr(8'd132, 32'h20);
        pad_in[5] = 1'b1;
        idle(2);
        check(irq, 0, "R5 not yet after two clocks");
        idle(1);
        check(irq, 1, "R5 event on third clock");
        rd(8'd128, 32'h20, "R5 status0");
        wr(8'd128, 32'hFFFF_FFDF);
        check(irq, 0, "R8 cleared irq");
        idle(3);
        rd(8'd128, 32'h0, "R5 single event per rise");
        // R6 level mode on line 40, status set while not enabled
        pad_in[40] = 1'b1;
        idle(4);
        check(irq, 0, "R9 disabled line no irq");
        rd(8'd129, 32'h100, "R9 status set while disabled");
        wr(8'd129, 32'h0);
        rd(8'd129, 32'h100, "R6 R8 level re-sets over clear");
        wr(8'd133, 32'h100);
        check(irq, 1, "R9 irq on enable");
        rd(8'd133, 32'h100, "R4 enable1");
        pad_in[40] = 1'b0;
        idle(4);
        wr(8'd129, 32'hFFFF_FEFF);
        check(irq, 0, "R8 irq after clear");
        rd(8'd129, 32'h0, "R6 status after input low");
        // R7 disabled triggers and receiver off
        wr(8'd70, 32'h0080_0000);
        wr(8'd71, 32'h03C0_0000);
        wr(8'd72, 32'h0000_0010);
        pad_in[72:70] = 3'b111;
        idle(5);
        rd(8'd130, 32'h0, "R7 no events");
        idle(4);
        if (n_bad == 0 && exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R4: %0d reads not returned, expected 0", exp_q.size());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule